// File: doc/BRIEF.md
# Three-output 16-bit PWM with one-shot mode

The block is a pulse-width modulator built around one 16-bit period counter that is shared by three outputs. Each output has its own duty register. The counter advances on one of three clock enables, chosen by a select input. It restarts after the number of ticks held in the period register. Each output is high while the count is below its duty value. An interrupt pulses at every period end.

Software pulses start and stop the channel. Edges on a selected trigger source can do the same. The three sources are an external pin, a comparator output and a timer interrupt. In free-running mode the channel repeats until it is stopped. In one-shot mode it produces exactly one period and then returns to idle on its own. Period and duty writes go to buffer registers. The active copies take them on start and at each period end, so a period that is already running is never torn.

The control state machine has three states. ST_IDLE means stopped: the outputs are low and the counter is zero. ST_FREE means free-running. ST_ONCE means one-shot. Its transitions are:
- GO: from ST_IDLE to ST_FREE or ST_ONCE, on a start event with no stop event in the same cycle.
- HALT: from ST_FREE or ST_ONCE to ST_IDLE, on a stop event.
- DONE: from ST_ONCE to ST_IDLE, at the period end.

Top module: `pwm16_unit`

## Requirements
- R1: After reset, all pwm_out bits and period_irq are 0 and the channel is idle.
- R2: While running, the count starts at 0 on start. It advances by one on each selected tick and returns to 0 after P ticks, where P is the active period, and a period of 0 behaves as 1. Output i is high exactly while the count is below its active duty.
- R3: A duty of 0 gives a constant low output, and a duty at or above the active period gives a constant high output while running. When idle, every output is low.
- R4: period_irq is high for one cycle, in the cycle after the tick that ends a period, and is low at all other times.
- R5: clk_sel values 0, 1 and 2 pick clk_en bit 0, 1 and 2 as the tick. clk_sel value 3 picks no tick, so the count and the outputs hold.
- R6: With oneshot_mode set at start, the channel runs one period, pulses period_irq at its end, and returns to idle with its outputs low.
- R7: A sw_start pulse starts an idle channel, and a sw_stop pulse returns the channel to idle at the next edge. A stop in the same cycle as a start wins. A start while running is ignored and the count goes on.
- R8: When trig_en is 1, a rising edge of trig_in[trig_sel] acts as a start and a falling edge acts as a stop. Here bit 0 is the pin, bit 1 the comparator and bit 2 the timer interrupt. Unselected bits, and all trigger bits while trig_en is 0, have no effect.
- R9: wr_period and wr_duty[i] write wr_data into buffer registers. The active period and duties take the buffer values at start and at each period end, never in mid-period.
- R10: The three outputs share the one counter and period, and each compares against its own duty register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 3 | Three candidate tick enables |
| clk_sel | input | 2 | Tick source select, 3 = none |
| trig_in | input | 3 | Trigger sources: pin, comparator, timer interrupt |
| trig_sel | input | 2 | Trigger source select |
| trig_en | input | 1 | Trigger edges may start and stop the channel |
| oneshot_mode | input | 1 | One-shot when set at start |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| wr_period | input | 1 | Write the period buffer |
| wr_duty | input | 3 | Write the duty buffer of each output |
| wr_data | input | 16 | Write data |
| pwm_out | output | 3 | PWM outputs |
| period_irq | output | 1 | Period-end pulse |

## Verification
The bench sweeps every period from 0 to 5 against duties from 0 to 7, in both modes, on each of the three tick sources. It predicts every output and interrupt cycle by cycle from a tick model. Periods of 0 and 1 catch an off-by-one wrap, which would stretch the period or make a wrong duty edge. Duties equal to and above the period catch a compare that drops low for the last count. Directed cases cover four further faults. A mid-period duty write would glitch the current period if it were applied at once. A restart on a second start would reset the count. A trigger that ignored its select would start on an unselected source. A one-shot that failed to stop would give a second interrupt.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FREE = 2'd1,
        ST_ONCE = 2'd2
    } pwm_state_t;
endpackage

// File: rtl/pwm16_ctrl.sv
module pwm16_ctrl
    import pwm16_pkg::*;
#(
    parameter int NUM_CLK  = 3,
    parameter int NUM_TRIG = 3,
    parameter int CSEL_W   = 2,
    parameter int TSEL_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CLK-1:0]  clk_en,
    input  logic [CSEL_W-1:0]   clk_sel,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [TSEL_W-1:0]   trig_sel,
    input  logic                trig_en,
    input  logic                oneshot_mode,
    input  logic                sw_start,
    input  logic                sw_stop,
    input  logic                period_end,
    output logic                tick,
    output logic                running,
    output logic                go,
    output logic                halt
);
    pwm_state_t          state_q, state_d;
    logic [NUM_TRIG-1:0] trig_q;
    logic                src_now, src_old;

    // pick the tick source; unmatched select codes give no tick
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_CLK; i++)
            if (clk_sel == CSEL_W'(i)) tick = clk_en[i];
    end

    always_comb begin
        src_now = 1'b0;
        src_old = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++)
            if (trig_sel == TSEL_W'(i)) begin
                src_now = trig_in[i];
                src_old = trig_q[i];
            end
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_in;

    assign halt = sw_stop | (trig_en & src_old & ~src_now);
    assign go   = (state_q == ST_IDLE) & ~halt &
                  (sw_start | (trig_en & src_now & ~src_old));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = oneshot_mode ? ST_ONCE : ST_FREE;
            ST_FREE: if (halt) state_d = ST_IDLE;
            ST_ONCE: if (halt || period_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;

    // outputs
    always_comb running = (state_q != ST_IDLE);

    a_r6_oneshot_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONCE && period_end) |=> (state_q == ST_IDLE));
    a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == ST_IDLE));
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && !halt) |=> (state_q == ST_FREE));
endmodule

// File: rtl/pwm16_counter.sv
module pwm16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             go,
    input  logic             halt,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             period_end,
    output logic             load,
    output logic             irq
);
    logic [CNT_W-1:0] per_buf, per_act;
    logic             wrap_now;

    assign wrap_now   = ({1'b0, cnt} + 1'b1) >= {1'b0, per_act};
    assign period_end = running & tick & wrap_now & ~halt;
    assign load       = go | period_end;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
            per_buf <= '0;
            per_act <= '0;
            cnt     <= '0;
            irq     <= 1'b0;
        end else begin
            if (wr_period) per_buf <= wr_data;
            if (load)      per_act <= per_buf;
            if (go || halt)          cnt <= '0;
            else if (running && tick) cnt <= wrap_now ? '0 : cnt + 1'b1;
            irq <= period_end;
        end

    a_r4_irq_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0));
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < per_act || cnt == '0));
    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !halt) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/pwm16_chan.sv
module pwm16_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic             running,
    output logic             pwm
);
    logic [CNT_W-1:0] duty_buf, duty_act;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
            duty_buf <= '0;
            duty_act <= '0;
        end else begin
            if (wr)   duty_buf <= wr_data;
            if (load) duty_act <= duty_buf;
        end

    assign pwm = running & (cnt < duty_act);

    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pwm);
endmodule

// File: rtl/pwm16_unit.sv
module pwm16_unit #(
    parameter int CNT_W    = 16,
    parameter int NUM_OUT  = 3,
    parameter int NUM_CLK  = 3,
    parameter int NUM_TRIG = 3,
    parameter int CSEL_W   = 2,
    parameter int TSEL_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CLK-1:0]  clk_en,
    input  logic [CSEL_W-1:0]   clk_sel,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [TSEL_W-1:0]   trig_sel,
    input  logic                trig_en,
    input  logic                oneshot_mode,
    input  logic                sw_start,
    input  logic                sw_stop,
    input  logic                wr_period,
    input  logic [NUM_OUT-1:0]  wr_duty,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [NUM_OUT-1:0]  pwm_out,
    output logic                period_irq
);
    logic             tick, running, go, halt, period_end, load;
    logic [CNT_W-1:0] cnt;

    pwm16_ctrl #(
        .NUM_CLK(NUM_CLK), .NUM_TRIG(NUM_TRIG), .CSEL_W(CSEL_W), .TSEL_W(TSEL_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_sel(clk_sel),
        .trig_in(trig_in), .trig_sel(trig_sel), .trig_en(trig_en),
        .oneshot_mode(oneshot_mode), .sw_start(sw_start), .sw_stop(sw_stop),
        .period_end(period_end), .tick(tick), .running(running),
        .go(go), .halt(halt)
    );

    pwm16_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .running(running), .go(go),
        .halt(halt), .wr_period(wr_period), .wr_data(wr_data), .cnt(cnt),
        .period_end(period_end), .load(load), .irq(period_irq)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        pwm16_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(load), .wr(wr_duty[g]),
            .wr_data(wr_data), .cnt(cnt), .running(running), .pwm(pwm_out[g])
        );
    end

    a_r4_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> $past(running));
endmodule

// File: tb/pwm16_unit_bench.sv
module pwm16_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_en = '0;
    logic [1:0]  clk_sel = '0;
    logic [2:0]  trig_in = '0;
    logic [1:0]  trig_sel = '0;
    logic        trig_en = 1'b0;
    logic        oneshot_mode = 1'b0;
    logic        sw_start = 1'b0;
    logic        sw_stop = 1'b0;
    logic        wr_period = 1'b0;
    logic [2:0]  wr_duty = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  pwm_out;
    logic        period_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit m_run, m_os;
    int m_c, m_sel;
    int m_pbuf, m_pact;
    int m_dbuf[3], m_dact[3];
    bit m_irq;
    logic [2:0] m_trig_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm16_unit u_pwm16_unit (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_sel(clk_sel),
        .trig_in(trig_in), .trig_sel(trig_sel), .trig_en(trig_en),
        .oneshot_mode(oneshot_mode), .sw_start(sw_start), .sw_stop(sw_stop),
        .wr_period(wr_period), .wr_duty(wr_duty), .wr_data(wr_data),
        .pwm_out(pwm_out), .period_irq(period_irq)
    );

    function automatic int peff();
        return (m_pact == 0) ? 1 : m_pact;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        for (int i = 0; i < 3; i++) begin
            bit e;
            e = m_run && (m_c < m_dact[i]);
            chk(pwm_out[i] == e, (i == 0) ? req : "R10", int'(pwm_out[i]), int'(e));
        end
        chk(period_irq == m_irq, "R4", int'(period_irq), int'(m_irq));
    endtask

    task automatic model_start();
        m_run = 1; m_c = 0; m_os = oneshot_mode; m_pact = m_pbuf;
        for (int i = 0; i < 3; i++) m_dact[i] = m_dbuf[i];
    endtask

    // one clock with given enables; model advances and outputs are checked
    task automatic step(input logic [2:0] en, input string req);
        bit tk;
        clk_en = en;
        tk = (m_sel < 3) ? en[m_sel] : 1'b0;
        @(negedge clk);
        m_irq = 0;
        if (m_run && tk) begin
            m_c++;
            if (m_c >= peff()) begin
                m_c = 0; m_irq = 1;
                m_pact = m_pbuf;
                for (int i = 0; i < 3; i++) m_dact[i] = m_dbuf[i];
                if (m_os) m_run = 0;
            end
        end
        compare(req);
    endtask

    task automatic wr_reg(input int which, input int val);
        clk_en = '0;
        wr_data = 16'(val);
        if (which == 3) wr_period = 1'b1;
        else wr_duty[which] = 1'b1;
        @(negedge clk);
        wr_period = 1'b0; wr_duty = '0;
        m_irq = 0;
        if (which == 3) m_pbuf = val; else m_dbuf[which] = val;
        compare("R9");
    endtask

    task automatic do_start(input string req);
        clk_en = '0; sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0; m_irq = 0;
        if (!m_run) model_start();
        compare(req);
    endtask

    task automatic do_stop(input string req);
        clk_en = '0; sw_stop = 1'b1;
        @(negedge clk);
        sw_stop = 1'b0; m_irq = 0; m_run = 0; m_c = 0;
        compare(req);
    endtask

    task automatic set_trig(input logic [2:0] v, input string req);
        bit now_b, old_b;
        clk_en = '0; trig_in = v;
        @(negedge clk);
        m_irq = 0;
        now_b = v[trig_sel]; old_b = m_trig_prev[trig_sel];
        if (trig_en && old_b && !now_b) begin m_run = 0; m_c = 0; end
        else if (trig_en && now_b && !old_b && !m_run) model_start();
        m_trig_prev = v;
        compare(req);
    endtask

    function automatic logic [2:0] pat(input int c);
        return {c % 3 == 1, c % 2 == 0, 1'b1};
    endfunction

    task automatic run_case(input int p, input int d, input bit os, input int sel);
        string tag;
        do_stop("R7");
        wr_reg(3, p);
        wr_reg(0, d);
        wr_reg(1, d / 2);
        wr_reg(2, 7 - d);
        oneshot_mode = os;
        clk_sel = 2'(sel); m_sel = sel;
        if (os) tag = "R6";
        else if (d == 0 || d >= ((p == 0) ? 1 : p)) tag = "R3";
        else tag = "R2";
        do_start(tag);
        for (int c = 0; c < 3 * ((p == 0) ? 1 : p) + 4; c++)
            step(pat(c), (sel != 0) ? "R5" : tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_dbuf[i] = 0; m_dact[i] = 0; end
        m_pbuf = 0; m_pact = 0; m_run = 0; m_c = 0; m_os = 0; m_sel = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwm_out == 3'b000, "R1", int'(pwm_out), 0);
        chk(period_irq == 1'b0, "R1", int'(period_irq), 0);

        // near-exhaustive sweep of period, duty, mode and tick source
        for (int sel = 0; sel < 3; sel++)
            for (int os = 0; os < 2; os++)
                for (int p = 0; p < 6; p++)
                    for (int d = 0; d < 8; d++)
                        run_case(p, d, os[0], sel);

        // R5: select code 3 gives no tick, outputs hold
        do_stop("R7");
        wr_reg(3, 3); wr_reg(0, 2); wr_reg(1, 1); wr_reg(2, 0);
        oneshot_mode = 1'b0; clk_sel = 2'd3; m_sel = 3;
        do_start("R5");
        for (int c = 0; c < 6; c++) step(3'b111, "R5");

        // R7: start while running ignored; stop wins over start
        clk_sel = 2'd0; m_sel = 0;
        wr_reg(3, 4); wr_reg(0, 2);
        do_stop("R7");
        do_start("R7");
        step(3'b001, "R7");
        step(3'b001, "R7");
        do_start("R7");
        chk(pwm_out[0] == 1'b0, "R7", int'(pwm_out[0]), 0);
        do_stop("R7");
        clk_en = '0; sw_start = 1'b1; sw_stop = 1'b1;
        @(negedge clk);
        sw_start = 1'b0; sw_stop = 1'b0; m_irq = 0;
        compare("R7");
        step(3'b001, "R7");

        // R9: buffered duty and period writes
        wr_reg(3, 4); wr_reg(0, 1);
        do_start("R9");
        step(3'b001, "R9");
        wr_reg(0, 3);
        for (int c = 0; c < 4; c++) step(3'b001, "R9");
        wr_reg(3, 2);
        for (int c = 0; c < 8; c++) step(3'b001, "R9");
        do_stop("R9");

        // R8: trigger edges
        wr_reg(3, 5); wr_reg(0, 5); wr_reg(1, 5); wr_reg(2, 5);
        oneshot_mode = 1'b0;
        trig_sel = 2'd1; trig_en = 1'b1;
        set_trig(3'b001, "R8");
        set_trig(3'b101, "R8");
        set_trig(3'b111, "R8");
        step(3'b001, "R8");
        set_trig(3'b110, "R8");
        set_trig(3'b100, "R8");
        trig_en = 1'b0;
        set_trig(3'b110, "R8");
        set_trig(3'b000, "R8");
        chk(pwm_out == 3'b000, "R8", int'(pwm_out), 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule